// File: doc/BRIEF.md
# Pseudo-SRAM Power and Standby Sequencer

This block drives the two chip-enable levels of a pseudo-static memory while the memory is powering up, entering or leaving deep power-down, or going into standby. It is the only driver of those levels until the memory is ready to be accessed. Once it reaches its ready state it raises a bus-ready flag and releases the active-low enable, and the access controller takes over the read and write protocol.

Every delay is a clock-cycle count taken from a parameter. Two helper functions in the package turn microseconds and nanoseconds into cycles. The long power-up and wake holds are measured in microseconds and scale with the clock-frequency parameter. A divide parameter shortens those holds so that a simulation run stays short.

The block has four inputs:
- a supply-good level;
- a level-sensitive power-down request;
- a level-sensitive wake request;
- an idle flag from the access controller, which is high when neither output enable nor write enable is active.

Top module: `psram_pwr_seq`

## Requirements
- R1: During reset and while the supply is not good, the state is RESET_WAIT, the active-low enable `ce1_n` is 1, the active-high enable `ce2` is 0 and `bus_ready` is 0. The state codes are RESET_WAIT=0, CE2_LOW_HOLD=1, WAKE_HOLD=2, READY=3, STBY_ENTRY=4, PD_SETUP=5, POWER_DOWN=6 and PD_EXIT_HOLD=7.
- R2: Once `supply_ok` is seen high, `ce2` stays low in CE2_LOW_HOLD for exactly LOW_CYC cycles. LOW_CYC is PWRUP_LOW_US converted to cycles.
- R3: Whenever `ce2` rises, `ce1_n` is already 1. On power-up, `ce2` is then high with `ce1_n` high for WAKE_CYC cycles (WAKE_HOLD_US converted to cycles) before READY.
- R4: `bus_ready` is 1 exactly when the state is READY, and `ce1_n` is 0 only in READY.
- R5: `ce2` falls for power-down only after passing through STBY_ENTRY and PD_SETUP. Before `ce2` falls, `ce1_n` has been high for at least SETUP_CYC cycles, and PD_SETUP itself lasts SETUP_CYC cycles.
- R6: In POWER_DOWN, `ce2` stays low for at least PDHOLD_CYC cycles. A wake request held from the start of POWER_DOWN leaves after exactly PDHOLD_CYC cycles. Without a wake request the block stays in POWER_DOWN.
- R7: On leaving power-down, `ce2` rises while `ce1_n` is high, and `ce1_n` stays high for WAKE_CYC cycles in PD_EXIT_HOLD before READY.
- R8: In READY, a power-down request is taken only in a cycle where `acc_idle` is 1. Until then the block stays in READY.
- R9: STBY_ENTRY lasts STBY_CYC cycles if `acc_idle` is 1 in every one of its cycles. If `acc_idle` is 0 in any of its cycles, it lasts CYCLE_CYC cycles.
- R10: A wake request in any state other than POWER_DOWN has no effect: the state does not change because of it.
- R11: If `supply_ok` goes low in any state, the next state is RESET_WAIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply has reached its minimum level |
| pd_req | input | 1 | Level request to enter deep power-down |
| wake_req | input | 1 | Level request to leave deep power-down |
| acc_idle | input | 1 | Access controller has output and write enables inactive |
| ce1_n | output | 1 | Active-low chip enable level (1 = forced deselect) |
| ce2 | output | 1 | Active-high chip enable level (0 = power-down) |
| bus_ready | output | 1 | Bus handed to the access controller |
| seq_state | output | 3 | Current sequencer state code |

## Verification
All outputs are decoded from the state register. An input that changes before a clock edge is therefore visible in the state, the enables and `bus_ready` one cycle later. A hold of N cycles shows the same state code on exactly N falling-edge samples.

Inputs are driven at the falling edge and outputs are sampled there too, before the next drive. Each dwell is measured by counting consecutive samples that show a given state code, and that count is compared with the cycle figures the bench computes from the clock and divide parameters. The enable levels are checked at the first sample of every new state, so every edge is seen in the order in which it happens.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;

  typedef enum logic [2:0] {
    RESET_WAIT   = 3'd0,
    CE2_LOW_HOLD = 3'd1,
    WAKE_HOLD    = 3'd2,
    READY        = 3'd3,
    STBY_ENTRY   = 3'd4,
    PD_SETUP     = 3'd5,
    POWER_DOWN   = 3'd6,
    PD_EXIT_HOLD = 3'd7
  } seq_state_e;

  // microsecond hold -> cycles, shortened by div, never below one cycle
  function automatic int unsigned us_cycles(int unsigned us, int unsigned mhz, int unsigned div);
    int unsigned r;
    r = (us * mhz) / div;
    return (r < 1) ? 1 : r;
  endfunction

  // nanosecond hold -> cycles, rounded up, never below one cycle
  function automatic int unsigned ns_cycles(int unsigned ns, int unsigned mhz);
    int unsigned r;
    r = (ns * mhz + 999) / 1000;
    return (r < 1) ? 1 : r;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_seq_timer.sv
module psram_seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          zero
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n) (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R2
  AST_TIMER_PARK: assert property (@(posedge clk) disable iff (!rst_n) (!load && zero) |=> zero); // R6

endmodule

// File: rtl/psram_seq_stby_guard.sv
module psram_seq_stby_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic in_stby,
  input  logic acc_idle,
  output logic viol_now
);

  logic viol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    viol_q <= 1'b0;
    else if (clear)                viol_q <= 1'b0;
    else if (in_stby && !acc_idle) viol_q <= 1'b1;
  end

  assign viol_now = viol_q | (in_stby & ~acc_idle);

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (viol_q && !clear) |=> viol_q); // R9

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
  import psram_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ       = 200,
  parameter int unsigned HOLD_DIV      = 1,
  parameter int unsigned PWRUP_LOW_US  = 50,
  parameter int unsigned WAKE_HOLD_US  = 350,
  parameter int unsigned CE1_SETUP_NS  = 10,
  parameter int unsigned PD_HOLD_NS    = 100,
  parameter int unsigned STBY_NS       = 20,
  parameter int unsigned CYCLE_NS      = 90
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       pd_req,
  input  logic       wake_req,
  input  logic       acc_idle,
  output logic       ce1_n,
  output logic       ce2,
  output logic       bus_ready,
  output logic [2:0] seq_state
);

  localparam int unsigned LOW_CYC    = us_cycles(PWRUP_LOW_US, CLK_MHZ, HOLD_DIV);
  localparam int unsigned WAKE_CYC   = us_cycles(WAKE_HOLD_US, CLK_MHZ, HOLD_DIV);
  localparam int unsigned SETUP_CYC  = ns_cycles(CE1_SETUP_NS, CLK_MHZ);
  localparam int unsigned PDHOLD_CYC = ns_cycles(PD_HOLD_NS, CLK_MHZ);
  localparam int unsigned STBY_CYC   = ns_cycles(STBY_NS, CLK_MHZ);
  localparam int unsigned CYCLE_CYC  = max2(ns_cycles(CYCLE_NS, CLK_MHZ), STBY_CYC);
  localparam int unsigned MAX_CYC    = max2(max2(LOW_CYC, WAKE_CYC), max2(PDHOLD_CYC, CYCLE_CYC + SETUP_CYC));
  localparam int          CW         = $clog2(MAX_CYC + 2);

  localparam logic [CW-1:0] LV_LOW    = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] LV_WAKE   = CW'(WAKE_CYC - 1);
  localparam logic [CW-1:0] LV_SETUP  = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] LV_PDHOLD = CW'(PDHOLD_CYC - 1);
  localparam logic [CW-1:0] LV_CYCLE  = CW'(CYCLE_CYC - 1);
  localparam logic [CW-1:0] LV_STBY_X = CW'(CYCLE_CYC - STBY_CYC);
  localparam logic [CW-1:0] RUN_MAX   = '1;

  seq_state_e    st, nxt;
  logic          ld, t_zero, viol_now;
  logic [CW-1:0] ld_val, t_cnt;

  // named events for the assertions
  logic enter_stby, stby_short_done;
  assign enter_stby      = (st == READY) && pd_req && acc_idle && supply_ok;
  assign stby_short_done = (st == STBY_ENTRY) && !viol_now && (t_cnt == LV_STBY_X);

  psram_seq_timer #(.CW(CW)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .cnt(t_cnt), .zero(t_zero)
  );

  psram_seq_stby_guard i_guard (
    .clk(clk), .rst_n(rst_n), .clear(enter_stby), .in_stby(st == STBY_ENTRY),
    .acc_idle(acc_idle), .viol_now(viol_now)
  );

  always_comb begin
    nxt    = st;
    ld     = 1'b0;
    ld_val = '0;
    if (!supply_ok) begin
      nxt = RESET_WAIT;
    end else begin
      unique case (st)
        RESET_WAIT: begin nxt = CE2_LOW_HOLD; ld = 1'b1; ld_val = LV_LOW; end
        CE2_LOW_HOLD: if (t_zero) begin nxt = WAKE_HOLD; ld = 1'b1; ld_val = LV_WAKE; end
        WAKE_HOLD: if (t_zero) nxt = READY;
        READY: if (enter_stby) begin nxt = STBY_ENTRY; ld = 1'b1; ld_val = LV_CYCLE; end
        STBY_ENTRY: if (t_zero || stby_short_done) begin nxt = PD_SETUP; ld = 1'b1; ld_val = LV_SETUP; end
        PD_SETUP: if (t_zero) begin nxt = POWER_DOWN; ld = 1'b1; ld_val = LV_PDHOLD; end
        POWER_DOWN: if (t_zero && wake_req) begin nxt = PD_EXIT_HOLD; ld = 1'b1; ld_val = LV_WAKE; end
        PD_EXIT_HOLD: if (t_zero) nxt = READY;
        default: nxt = RESET_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= RESET_WAIT;
    else        st <= nxt;
  end

  assign ce2       = !(st == RESET_WAIT || st == CE2_LOW_HOLD || st == POWER_DOWN);
  assign ce1_n     = (st != READY);
  assign bus_ready = (st == READY);
  assign seq_state = st;

  // run-length observers of the enable levels, for spacing assertions only
  logic [CW-1:0] ce1_hi_run, ce2_lo_run, ce2_hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce1_hi_run <= '0;
      ce2_lo_run <= '0;
      ce2_hi_run <= '0;
    end else begin
      ce1_hi_run <= !ce1_n ? '0 : (ce1_hi_run == RUN_MAX ? ce1_hi_run : ce1_hi_run + 1'b1);
      ce2_lo_run <=  ce2   ? '0 : (ce2_lo_run == RUN_MAX ? ce2_lo_run : ce2_lo_run + 1'b1);
      ce2_hi_run <= !ce2   ? '0 : (ce2_hi_run == RUN_MAX ? ce2_hi_run : ce2_hi_run + 1'b1);
    end
  end

  AST_CE1_HIGH_AT_CE2_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ce2) |-> ce1_n); // R3
  AST_CE2_HIGH_BEFORE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) $fell(ce1_n) |-> (ce2_hi_run >= CW'(WAKE_CYC))); // R7
  AST_PD_ONLY_FROM_SETUP: assert property (@(posedge clk) disable iff (!rst_n) ($fell(ce2) && st == POWER_DOWN) |-> ($past(st) == PD_SETUP)); // R5
  AST_CE1_SETUP_BEFORE_PD: assert property (@(posedge clk) disable iff (!rst_n) ($fell(ce2) && st == POWER_DOWN) |-> (ce1_hi_run >= CW'(SETUP_CYC))); // R5
  AST_PD_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ($rose(ce2) && st == PD_EXIT_HOLD) |-> (ce2_lo_run >= CW'(PDHOLD_CYC))); // R6
  AST_STBY_LONG_ON_VIOL: assert property (@(posedge clk) disable iff (!rst_n) ($past(st) == STBY_ENTRY && st == PD_SETUP && $past(viol_now)) |-> ($past(t_cnt) == '0)); // R9
  AST_SUPPLY_LOSS: assert property (@(posedge clk) disable iff (!rst_n) !supply_ok |=> (st == RESET_WAIT)); // R11

endmodule

// File: tb/test_psram_pwr_seq.sv
`timescale 1ns/1ps
module test_psram_pwr_seq;

  localparam int MHZ = 200;
  localparam int DIV = 1000;
  localparam int E_LOW   = 50 * MHZ / DIV;   // 10
  localparam int E_WAKE  = 350 * MHZ / DIV;  // 70
  localparam int E_SETUP = 2;                // 10 ns at 5 ns
  localparam int E_PDH   = 20;               // 100 ns
  localparam int E_STBY  = 4;                // 20 ns
  localparam int E_CYC   = 18;               // 90 ns

  localparam int S_RST = 0, S_LOW = 1, S_WAKE = 2, S_RDY = 3, S_STBY = 4, S_SET = 5, S_PD = 6, S_EXIT = 7;

  logic clk = 0, rst_n = 0, supply_ok = 0, pd_req = 0, wake_req = 0, acc_idle = 1;
  logic ce1_n, ce2, bus_ready;
  logic [2:0] seq_state;
  int tests = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  psram_pwr_seq #(.CLK_MHZ(MHZ), .HOLD_DIV(DIV)) i_psram_pwr_seq (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pd_req(pd_req), .wake_req(wake_req),
    .acc_idle(acc_idle), .ce1_n(ce1_n), .ce2(ce2), .bus_ready(bus_ready), .seq_state(seq_state)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_state(input int s);
    for (int i = 0; i < 2000 && seq_state != s; i++) @(negedge clk);
  endtask

  // count consecutive negedge samples in state s (called when already there)
  task automatic dwell(input int s, output int n);
    n = 0;
    while (seq_state == s && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(seq_state == S_RST, "R1 state", seq_state, S_RST);
    chk(ce1_n == 1 && ce2 == 0 && bus_ready == 0, "R1 pins", {ce1_n, ce2, bus_ready}, 3'b100);
  endtask

  task automatic t_powerup();
    int n;
    supply_ok = 1;
    @(negedge clk);
    chk(seq_state == S_LOW && ce2 == 0, "R2 enter low hold", seq_state, S_LOW);
    dwell(S_LOW, n);
    chk(n == E_LOW, "R2 ce2 low dwell", n, E_LOW);
    chk(seq_state == S_WAKE && ce2 == 1 && ce1_n == 1, "R3 ce2 up with ce1 high", {ce2, ce1_n}, 2'b11);
    dwell(S_WAKE, n);
    chk(n == E_WAKE, "R3 wake hold dwell", n, E_WAKE);
    chk(seq_state == S_RDY && bus_ready == 1 && ce1_n == 0, "R4 ready", {bus_ready, ce1_n}, 2'b10);
  endtask

  task automatic t_wake_ignored();
    wake_req = 1;
    for (int i = 0; i < 6; i++) @(negedge clk);
    chk(seq_state == S_RDY && bus_ready == 1, "R10 wake in ready ignored", seq_state, S_RDY);
    wake_req = 0;
  endtask

  task automatic t_pd_cycle(input bit violate, input bit early_wake);
    int n;
    acc_idle = 0; pd_req = 1;
    for (int i = 0; i < 10; i++) @(negedge clk);
    chk(seq_state == S_RDY && bus_ready == 1, "R8 deferred while busy", seq_state, S_RDY);
    acc_idle = 1;
    @(negedge clk);
    chk(seq_state == S_STBY && ce1_n == 1 && bus_ready == 0, "R4 ce1 high in standby entry", seq_state, S_STBY);
    pd_req = 0;
    if (violate) begin acc_idle = 0; @(negedge clk); acc_idle = 1; dwell(S_STBY, n); n++; end
    else dwell(S_STBY, n);
    chk(n == (violate ? E_CYC : E_STBY), "R9 standby entry dwell", n, violate ? E_CYC : E_STBY);
    chk(seq_state == S_SET && ce1_n == 1 && ce2 == 1, "R5 setup before ce2 falls", {ce1_n, ce2}, 2'b11);
    dwell(S_SET, n);
    chk(n == E_SETUP, "R5 setup dwell", n, E_SETUP);
    chk(seq_state == S_PD && ce2 == 0 && ce1_n == 1, "R5 power-down pins", {ce1_n, ce2}, 2'b10);
    if (early_wake) begin
      wake_req = 1;
      dwell(S_PD, n);
      chk(n == E_PDH, "R6 pd dwell with early wake", n, E_PDH);
    end else begin
      for (int i = 0; i < 40; i++) @(negedge clk);
      chk(seq_state == S_PD && ce2 == 0, "R6 stays in pd without wake", seq_state, S_PD);
      wake_req = 1;
      @(negedge clk);
    end
    wake_req = 0;
    chk(seq_state == S_EXIT && ce2 == 1 && ce1_n == 1, "R7 ce2 up with ce1 high", {ce2, ce1_n}, 2'b11);
    dwell(S_EXIT, n);
    chk(n == E_WAKE, "R7 exit hold dwell", n, E_WAKE);
    chk(seq_state == S_RDY && bus_ready == 1, "R7 ready after exit", seq_state, S_RDY);
  endtask

  task automatic t_supply_loss();
    pd_req = 1;
    @(negedge clk);
    supply_ok = 0;
    pd_req = 0;
    @(negedge clk);
    chk(seq_state == S_RST && ce2 == 0 && ce1_n == 1 && bus_ready == 0, "R11 supply loss", seq_state, S_RST);
    wake_req = 1;
    @(negedge clk);
    chk(seq_state == S_RST, "R10 wake in reset wait ignored", seq_state, S_RST);
    wake_req = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_powerup();
    t_wake_ignored();
    t_pd_cycle(1'b0, 1'b1);
    t_pd_cycle(1'b1, 1'b0);
    t_supply_loss();
    t_powerup();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule